// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Access Protection

This block turns a virtual page number into a physical frame number for data accesses. Every stored entry is compared against the incoming page number and an 8-bit address-space tag in the same cycle. The frame number of the matching entry is joined to the untranslated 13-bit page offset to form the physical address. Each entry carries four permission enables, one for each pairing of privilege (kernel or user) and direction (read or write). The access type of the request is checked against these enables while the lookup runs. When the access is not allowed, the response reports a protection fault.

Software keeps the contents up to date. No hardware walks the page tables. A write port installs or clears one entry per cycle. A separate strobe drops every entry at once. A miss is reported in the response, and software then refills the buffer. Each entry also has a use bit, which any matching lookup sets. Each entry has a dirty bit, which software installs. A permitted write that lands on a clean page makes the response ask software to mark that page dirty.

Lookups travel over a valid/ready request channel and return on a valid/ready response channel. The response appears one cycle after the request is taken. The block can hold only one response. While that response waits with `rsp_ready` low, `req_ready` stays low and the held response does not change. When the consumer takes the response, a new request can be accepted in that same cycle. The write port and the global invalidate are plain strobes with no handshake.

Top module: `tlb_xlate`

## Requirements
- R1: A request hits when a valid entry has the same page number and the same address-space tag. The hit response carries `rsp_hit`=1, `rsp_miss`=0, and `rsp_paddr` = {entry frame number, request offset}. The 13-bit offset passes through unchanged.
- R2: A request that matches no valid entry returns `rsp_miss`=1, `rsp_hit`=0, `rsp_fault`=0 and `rsp_paddr`=0. A different address-space tag alone is enough to cause a miss.
- R3: The permission field `wr_perm` uses four bits. Bit 0 allows kernel read, bit 1 kernel write, bit 2 user read and bit 3 user write. Kernel is `req_user`=0, and read is `req_write`=0. If the enable for the request's access type is clear, a hit returns `rsp_fault`=1 with `rsp_hit`=1, and `rsp_paddr` still holds the translation.
- R4: Any lookup that matches an entry sets that entry's use bit, including lookups that fault. `rsp_used` reports the use bit as it was before the lookup. Installing an entry clears its use bit.
- R5: `rsp_mark_dirty`=1 only for a write hit that the permissions allow, on an entry whose installed dirty bit is 0.
- R6: If several valid entries match, the entry with the lowest index supplies the frame number, the use bit and the permissions, and `rsp_multi`=1.
- R7: With `wr_en`=1, entry `wr_idx` takes the new page number, tag, frame, permissions and dirty bit, and its valid bit becomes `wr_valid`. The change affects lookups accepted from the next cycle on. A lookup accepted in the same cycle sees the old contents. When that same-cycle lookup hits the entry being written, the write decides the use bit.
- R8: `inv_all`=1 clears every valid bit at the next clock edge. A `wr_en` with `wr_valid`=1 in the same cycle still installs its entry.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. A request accepted at an edge gives `rsp_valid`=1 after that edge. While `rsp_valid`=1 and `rsp_ready`=0, all response fields stay unchanged.
- R10: After reset, `rsp_valid`=0, `req_ready`=1, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_vpn | input | 19 | Virtual page number |
| req_off | input | 13 | Page offset |
| req_asn | input | 8 | Address-space tag |
| req_user | input | 1 | 1 = user access, 0 = kernel access |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_fault | output | 1 | The access type is not allowed |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_paddr | output | 31 | Physical address |
| rsp_used | output | 1 | Use bit of the entry before this lookup |
| rsp_mark_dirty | output | 1 | Software should mark the page dirty |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 7 | Entry index to write |
| wr_valid | input | 1 | Valid bit to store (0 clears the entry) |
| wr_vpn | input | 19 | Page number to store |
| wr_asn | input | 8 | Address-space tag to store |
| wr_pfn | input | 18 | Frame number to store |
| wr_perm | input | 4 | Permission enables, bit layout as in R3 |
| wr_dirty | input | 1 | Dirty bit to store |
| inv_all | input | 1 | Clear every valid bit |

## Verification
The entry write port can act on the same entry that a lookup hits in the same cycle. The bench provokes this by driving a lookup of entry 5 and an overwrite of entry 5 across a single clock edge. That response must show the old frame number with the use bit set. The next lookup must show the new frame number with a cleared use bit, so the write wins. A global invalidate is also issued together with a fresh install. The bench then checks that old translations miss and the newly installed one hits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Bit positions inside the 4-bit permission field; the lookup indexes
  // the field with {user, write}, so these positions are behaviour.
  localparam int PERM_W      = 4;
  localparam int PERM_SUP_RD = 0;
  localparam int PERM_SUP_WR = 1;
  localparam int PERM_USR_RD = 2;
  localparam int PERM_USR_WR = 3;

  function automatic logic [1:0] access_sel(input logic user, input logic write);
    return {user, write};
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 19,
  parameter int ASN_W   = 8,
  parameter int PFN_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_valid,
  input  logic [VPN_W-1:0]          wr_vpn,
  input  logic [ASN_W-1:0]          wr_asn,
  input  logic [PFN_W-1:0]          wr_pfn,
  input  logic [tlb_pkg::PERM_W-1:0] wr_perm,
  input  logic                      wr_dirty,
  input  logic                      inv_all,
  input  logic                      touch_en,
  input  logic [IDX_W-1:0]          touch_idx,
  input  logic [VPN_W-1:0]          lk_vpn,
  input  logic [ASN_W-1:0]          lk_asn,
  output logic [ENTRIES-1:0]        match_vec,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [PFN_W-1:0]          rd_pfn,
  output logic [tlb_pkg::PERM_W-1:0] rd_perm,
  output logic                      rd_dirty,
  output logic                      rd_use
);
  logic                       valid_q [ENTRIES];
  logic                       use_q   [ENTRIES];
  logic [VPN_W-1:0]           vpn_q   [ENTRIES];
  logic [ASN_W-1:0]           asn_q   [ENTRIES];
  logic [PFN_W-1:0]           pfn_q   [ENTRIES];
  logic [tlb_pkg::PERM_W-1:0] perm_q  [ENTRIES];
  logic                       dirty_q [ENTRIES];
  logic [ENTRIES-1:0]         valid_vec;
  logic [ENTRIES-1:0]         use_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        use_q[g]   <= 1'b0;
      end else if (hit_wr) begin
        valid_q[g] <= wr_valid;
        use_q[g]   <= 1'b0;
      end else begin
        if (inv_all) valid_q[g] <= 1'b0;
        if (touch_en && touch_idx == IDX_W'(g)) use_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        vpn_q[g]   <= wr_vpn;
        asn_q[g]   <= wr_asn;
        pfn_q[g]   <= wr_pfn;
        perm_q[g]  <= wr_perm;
        dirty_q[g] <= wr_dirty;
      end
    end

    assign valid_vec[g] = valid_q[g];
    assign use_vec[g]   = use_q[g];
    assign match_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (asn_q[g] == lk_asn);
  end

  assign rd_pfn   = pfn_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_use   = use_q[rd_idx];

  // R8: a global invalidate without a write leaves no entry valid
  p_inv_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !wr_en |=> valid_vec == '0);
  // R7: the written entry takes the requested valid bit
  p_install_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_vec[$past(wr_idx)] == $past(wr_valid));
  // R4: a touched entry has its use bit set unless overwritten
  p_touch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en && !(wr_en && wr_idx == touch_idx) |=> use_vec[$past(touch_idx)]);
endmodule

// File: rtl/tlb_match_select.sv
module tlb_match_select #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any,
  output logic               multi,
  output logic [IDX_W-1:0]   sel_idx
);
  localparam logic [ENTRIES-1:0] ONE = ENTRIES'(1);

  always_comb begin
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) sel_idx = IDX_W'(i);
    end
  end

  always_comb begin
    any   = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        if (any) multi = 1'b1;
        any = 1'b1;
      end
    end
  end

  // R6: more than one match is flagged
  p_multi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(match_vec) > 1) |-> multi);
  // R6: the chosen entry matches and no lower-indexed entry does
  p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> match_vec[sel_idx] && ((match_vec & ((ONE << sel_idx) - ONE)) == '0));
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check (
  input  logic [tlb_pkg::PERM_W-1:0] perm,
  input  logic                       user,
  input  logic                       write,
  output logic                       allow
);
  assign allow = perm[tlb_pkg::access_sel(user, write)];
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 19,
  parameter int OFF_W   = 13,
  parameter int ASN_W   = 8,
  parameter int PFN_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VPN_W-1:0]           req_vpn,
  input  logic [OFF_W-1:0]           req_off,
  input  logic [ASN_W-1:0]           req_asn,
  input  logic                       req_user,
  input  logic                       req_write,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_hit,
  output logic                       rsp_miss,
  output logic                       rsp_fault,
  output logic                       rsp_multi,
  output logic [PA_W-1:0]            rsp_paddr,
  output logic                       rsp_used,
  output logic                       rsp_mark_dirty,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic                       wr_valid,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [ASN_W-1:0]           wr_asn,
  input  logic [PFN_W-1:0]           wr_pfn,
  input  logic [tlb_pkg::PERM_W-1:0] wr_perm,
  input  logic                       wr_dirty,
  input  logic                       inv_all
);
  logic [ENTRIES-1:0]         match_vec;
  logic                       any, multi, allow, accept;
  logic [IDX_W-1:0]           sel_idx;
  logic [PFN_W-1:0]           rd_pfn;
  logic [tlb_pkg::PERM_W-1:0] rd_perm;
  logic                       rd_dirty, rd_use;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PFN_W(PFN_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vpn(wr_vpn),
    .wr_asn(wr_asn), .wr_pfn(wr_pfn), .wr_perm(wr_perm), .wr_dirty(wr_dirty),
    .inv_all(inv_all), .touch_en(accept && any), .touch_idx(sel_idx),
    .lk_vpn(req_vpn), .lk_asn(req_asn), .match_vec(match_vec),
    .rd_idx(sel_idx), .rd_pfn(rd_pfn), .rd_perm(rd_perm),
    .rd_dirty(rd_dirty), .rd_use(rd_use)
  );

  tlb_match_select #(.ENTRIES(ENTRIES)) u_sel (
    .clk(clk), .rst_n(rst_n), .match_vec(match_vec),
    .any(any), .multi(multi), .sel_idx(sel_idx)
  );

  tlb_perm_check u_perm (
    .perm(rd_perm), .user(req_user), .write(req_write), .allow(allow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_miss       <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_multi      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_used       <= 1'b0;
      rsp_mark_dirty <= 1'b0;
    end else if (accept) begin
      rsp_valid      <= 1'b1;
      rsp_hit        <= any;
      rsp_miss       <= !any;
      rsp_fault      <= any && !allow;
      rsp_multi      <= multi;
      rsp_paddr      <= any ? {rd_pfn, req_off} : '0;
      rsp_used       <= any && rd_use;
      rsp_mark_dirty <= any && allow && req_write && !rd_dirty;
    end else if (rsp_ready) begin
      rsp_valid      <= 1'b0;
    end
  end

  // R9: a held response does not change
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit) && $stable(rsp_fault));
  // R9: an accepted request yields a response after one edge
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  // R3: a fault is only reported on a hit
  p_fault_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_hit);
  // R5: a dirty request only on a permitted hit
  p_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_mark_dirty |-> rsp_hit && !rsp_fault);
  // R2: a miss carries a zero address and no fault
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> rsp_paddr == '0 && !rsp_fault && !rsp_hit);
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [18:0] req_vpn = '0;
  logic [12:0] req_off = '0;
  logic [7:0]  req_asn = '0;
  logic        req_user = 1'b0, req_write = 1'b0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic        rsp_hit, rsp_miss, rsp_fault, rsp_multi, rsp_used, rsp_mark_dirty;
  logic [30:0] rsp_paddr;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_dirty = 1'b0, inv_all = 1'b0;
  logic [6:0]  wr_idx = '0;
  logic [18:0] wr_vpn = '0;
  logic [7:0]  wr_asn = '0;
  logic [17:0] wr_pfn = '0;
  logic [3:0]  wr_perm = '0;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_off(req_off), .req_asn(req_asn), .req_user(req_user),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_multi(rsp_multi),
    .rsp_paddr(rsp_paddr), .rsp_used(rsp_used), .rsp_mark_dirty(rsp_mark_dirty),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vpn(wr_vpn), .wr_asn(wr_asn),
    .wr_pfn(wr_pfn), .wr_perm(wr_perm), .wr_dirty(wr_dirty), .inv_all(inv_all)
  );

  typedef struct packed {
    logic [18:0] vpn;
    logic [7:0]  asn;
    logic [12:0] off;
    logic        usr;
    logic        wr;
    logic        hit;
    logic        flt;
    logic        mlt;
    logic [30:0] pa;
    logic        used;
    logic        md;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{19'h00123, 8'h07, 13'h1ABC, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, {18'h2AB0C, 13'h1ABC}, 1'b0, 1'b0},
    '{19'h00123, 8'h07, 13'h0004, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, {18'h2AB0C, 13'h0004}, 1'b1, 1'b1},
    '{19'h00123, 8'h08, 13'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0, 1'b0, 1'b0},
    '{19'h00456, 8'h07, 13'h0100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, {18'h01111, 13'h0100}, 1'b0, 1'b0},
    '{19'h00456, 8'h07, 13'h0101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, {18'h01111, 13'h0101}, 1'b1, 1'b0},
    '{19'h00789, 8'h03, 13'h0002, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, {18'h3FFFF, 13'h0002}, 1'b0, 1'b0},
    '{19'h00789, 8'h03, 13'h0003, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, {18'h3FFFF, 13'h0003}, 1'b1, 1'b0},
    '{19'h7FFFF, 8'hFF, 13'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, {18'h00001, 13'h0000}, 1'b0, 1'b0},
    '{19'h7FFFF, 8'hFF, 13'h1FFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, {18'h00001, 13'h1FFF}, 1'b1, 1'b1},
    '{19'h00AAA, 8'h01, 13'h0010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, {18'h00040, 13'h0010}, 1'b0, 1'b0},
    '{19'h00AAA, 8'h01, 13'h0011, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, {18'h00040, 13'h0011}, 1'b1, 1'b0},
    '{19'h00124, 8'h07, 13'h0004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic install(input logic [6:0] idx, input logic v, input logic [18:0] vpn,
                         input logic [7:0] asn, input logic [17:0] pfn,
                         input logic [3:0] perm, input logic d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_vpn = vpn;
    wr_asn = asn; wr_pfn = pfn; wr_perm = perm; wr_dirty = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive_req(input logic [18:0] vpn, input logic [7:0] asn,
                           input logic [12:0] off, input logic usr, input logic wr);
    req_valid = 1'b1; req_vpn = vpn; req_asn = asn;
    req_off = off; req_user = usr; req_write = wr;
  endtask

  // drive at a falling edge, sample at the falling edge after the accepting rise
  task automatic lookup(input logic [18:0] vpn, input logic [7:0] asn,
                        input logic [12:0] off, input logic usr, input logic wr);
    @(negedge clk);
    drive_req(vpn, asn, off, usr, wr);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] pack_rsp();
    return {26'b0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi, rsp_used, rsp_mark_dirty, rsp_paddr};
  endfunction

  function automatic logic [63:0] pack_exp(input logic hit, input logic flt, input logic mlt,
                                           input logic used, input logic md, input logic [30:0] pa);
    return {26'b0, 1'b1, hit, !hit, flt, mlt, used, md, pa};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R10 req_ready after reset", 64'(req_ready), 64'd1);
    lookup(19'h00000, 8'h00, 13'h0000, 1'b0, 1'b0);
    check("R10 empty buffer misses", pack_rsp(), pack_exp(0, 0, 0, 0, 0, 31'h0));

    // perm layout: bit0 kernel read, bit1 kernel write, bit2 user read, bit3 user write
    install(7'd5,   1'b1, 19'h00123, 8'h07, 18'h2AB0C, 4'b1111, 1'b0);
    install(7'd9,   1'b1, 19'h00456, 8'h07, 18'h01111, 4'b0101, 1'b1);
    install(7'd20,  1'b1, 19'h00789, 8'h03, 18'h3FFFF, 4'b0011, 1'b1);
    install(7'd127, 1'b1, 19'h7FFFF, 8'hFF, 18'h00001, 4'b1010, 1'b0);
    install(7'd60,  1'b1, 19'h00AAA, 8'h01, 18'h00060, 4'b1111, 1'b1);
    install(7'd40,  1'b1, 19'h00AAA, 8'h01, 18'h00040, 4'b1111, 1'b1);

    // R1 R2 R3 R4 R5 R6: table walk
    for (int i = 0; i < 12; i++) begin
      string tag;
      lookup(TBL[i].vpn, TBL[i].asn, TBL[i].off, TBL[i].usr, TBL[i].wr);
      if (TBL[i].mlt)       tag = "R6 multi-match row";
      else if (TBL[i].md)   tag = "R5 dirty request row";
      else if (TBL[i].flt)  tag = "R3 protection row";
      else if (!TBL[i].hit) tag = "R2 miss row";
      else                  tag = "R1 translation row";
      check(tag, pack_rsp(), pack_exp(TBL[i].hit, TBL[i].flt, TBL[i].mlt, TBL[i].used, TBL[i].md, TBL[i].pa));
      check("R4 use bit row", 64'(rsp_used), 64'(TBL[i].used));
    end

    // R7: lookup and overwrite of entry 5 in one cycle
    @(negedge clk);
    drive_req(19'h00123, 8'h07, 13'h0A0A, 1'b0, 1'b0);
    wr_en = 1'b1; wr_idx = 7'd5; wr_valid = 1'b1; wr_vpn = 19'h00123;
    wr_asn = 8'h07; wr_pfn = 18'h00055; wr_perm = 4'b1111; wr_dirty = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check("R7 same-cycle lookup sees old entry", pack_rsp(), pack_exp(1, 0, 0, 1, 0, {18'h2AB0C, 13'h0A0A}));
    lookup(19'h00123, 8'h07, 13'h0A0A, 1'b0, 1'b0);
    check("R7 new entry, use cleared by write", pack_rsp(), pack_exp(1, 0, 0, 0, 0, {18'h00055, 13'h0A0A}));
    install(7'd9, 1'b0, 19'h00456, 8'h07, 18'h01111, 4'b0101, 1'b1);
    lookup(19'h00456, 8'h07, 13'h0001, 1'b1, 1'b0);
    check("R7 cleared entry misses", pack_rsp(), pack_exp(0, 0, 0, 0, 0, 31'h0));

    // R8: global invalidate with a same-cycle install
    @(negedge clk);
    inv_all = 1'b1;
    wr_en = 1'b1; wr_idx = 7'd3; wr_valid = 1'b1; wr_vpn = 19'h00333;
    wr_asn = 8'h02; wr_pfn = 18'h00333; wr_perm = 4'b0001; wr_dirty = 1'b0;
    @(negedge clk);
    inv_all = 1'b0; wr_en = 1'b0;
    lookup(19'h00123, 8'h07, 13'h0000, 1'b0, 1'b0);
    check("R8 old entry gone", pack_rsp(), pack_exp(0, 0, 0, 0, 0, 31'h0));
    lookup(19'h00AAA, 8'h01, 13'h0000, 1'b0, 1'b0);
    check("R8 multi entries gone", pack_rsp(), pack_exp(0, 0, 0, 0, 0, 31'h0));
    lookup(19'h00333, 8'h02, 13'h0777, 1'b0, 1'b0);
    check("R8 same-cycle install kept", pack_rsp(), pack_exp(1, 0, 0, 0, 0, {18'h00333, 13'h0777}));

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    drive_req(19'h00333, 8'h02, 13'h0123, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 response after one edge", pack_rsp(), pack_exp(1, 0, 0, 1, 0, {18'h00333, 13'h0123}));
    check("R9 ready low while held", 64'(req_ready), 64'd0);
    drive_req(19'h00123, 8'h07, 13'h0000, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 held response stable", pack_rsp(), pack_exp(1, 0, 0, 1, 0, {18'h00333, 13'h0123}));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 waiting request taken on release", pack_rsp(), pack_exp(0, 0, 0, 0, 0, 31'h0));
    @(negedge clk);
    check("R9 response drained", 64'(rsp_valid), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule